// File: doc/BRIEF.md
# Pin Event Interrupt Controller

This block watches a bank of general-purpose input pins and turns their activity into interrupt requests. Every pin owns four event flags: two that follow its current level (low, high) and two that remember transitions (falling, rising). The pins are first brought into the clock domain through a synchroniser. The level flags follow the synchronised value directly. The transition flags are held until software clears them by writing ones.

Three independent target sets share the same event flags: one for each of two processors and one for waking the system from a low-power state. Each set has its own enable mask and its own force mask. It computes a read-only status word and drives one interrupt line. Software reaches all registers through a simple single-cycle word bus. Writes are captured on the clock edge, and read data is combinational on the selected address.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: The four flags of pin N sit in word N/8 of a register group, at bits 4*(N%8)+3 down to 4*(N%8). Within a flag nibble, bit 0 is level low, bit 1 is level high, bit 2 is falling edge and bit 3 is rising edge.
- R2: The level flags are not stored. Two clock edges after a pin changes, level low equals the inverted pin and level high equals the pin, and a level flag drops once the pin leaves that level.
- R3: A rising (falling) transition of the synchronised pin sets the rising (falling) flag three edges after the pin change. The flag then stays set until it is cleared.
- R4: A bus write to the raw group (region 0) clears the edge flags whose data bits are 1. It leaves edge flags under 0 bits untouched, and it has no effect on level flags.
- R5: When a clear of an edge flag and a new edge of the same kind fall in the same clock cycle, the flag ends up set.
- R6: Each set's status word equals (raw OR force) AND enable. Status words ignore bus writes.
- R7: Interrupt line s (bit 0 for processor 0, bit 1 for processor 1, bit 2 for wake) is high exactly when any status bit of set s is high. The sets do not affect one another.
- R8: After reset all enable, force and edge flags are zero and all interrupt lines are low.
- R9: Address = {region[3:0], word index}. Region 0 is raw. Set s uses region 1+3s for enable, 2+3s for force and 3+3s for status. Other regions read zero. Enable and force bits belonging to pins beyond the parameterised count stay zero, and so do raw bits for those pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Asynchronous pin levels |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 4+IDX_W | Region and word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle |
| irq_o | output | 3 | Interrupt lines: processor 0, processor 1, wake |

## Verification
The bench builds the block with NUM_PINS set to 12. This gives two words per register group, and the second word is only half populated. The masking of enable, force and raw bits for absent pins can therefore be seen at the bus. The bench also checks that a full-word write to the upper word keeps only the four real nibbles. With the index field only one bit wide, a small bench can reach every region and every word, including the unused regions.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
   localparam int PINS_PER_WORD = 8;
   localparam int EV_BITS       = 4;
   localparam int WORD_W        = 32;
   localparam int NUM_SETS      = 3;
   localparam int REGION_W      = 4;
   localparam int MAX_FLAT      = 128;

   // event bit positions inside a pin nibble
   localparam int EV_LVL_LO = 0;
   localparam int EV_LVL_HI = 1;
   localparam int EV_FALL   = 2;
   localparam int EV_RISE   = 3;

   localparam logic [REGION_W-1:0] REGION_RAW = '0;

   typedef enum logic [1:0] {
      SEL_ENABLE = 2'd0,
      SEL_FORCE  = 2'd1,
      SEL_STATUS = 2'd2
   } set_reg_e;

   function automatic logic [REGION_W-1:0] set_region(int s, set_reg_e r);
      return REGION_W'(1 + 3 * s + int'(r));
   endfunction

   function automatic logic [MAX_FLAT-1:0] low_mask(int n);
      logic [MAX_FLAT-1:0] m;
      m = '0;
      for (int i = 0; i < MAX_FLAT; i++) if (i < n) m[i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
module gpio_irq_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);
   logic [STAGES-1:0][W-1:0] chain_q;

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      chain_q[k] <= '0;
            else if (k == 0) chain_q[k] <= async_i;
            else             chain_q[k] <= chain_q[(k == 0) ? 0 : k - 1];
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_events.sv
`timescale 1ns/1ps
module gpio_irq_events import gpio_irq_pkg::*; #(
   parameter int NUM_PINS = 32,
   parameter int FLAT_W   = 128
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic [FLAT_W-1:0]   clr_i,
   output logic [FLAT_W-1:0]   raw_o,
   output logic [NUM_PINS-1:0] prev_o
);
   logic [NUM_PINS-1:0] prev_q, rise_q, fall_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pin_i;
   end

   generate
      for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
         // a fresh edge overrides a same-cycle clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rise_q[n] <= 1'b0;
               fall_q[n] <= 1'b0;
            end else begin
               rise_q[n] <= (rise_q[n] & ~clr_i[EV_BITS*n+EV_RISE]) | (pin_i[n] & ~prev_q[n]);
               fall_q[n] <= (fall_q[n] & ~clr_i[EV_BITS*n+EV_FALL]) | (~pin_i[n] & prev_q[n]);
            end
         end
      end
   endgenerate

   always_comb begin
      raw_o = '0;
      for (int n = 0; n < NUM_PINS; n++) begin
         raw_o[EV_BITS*n+EV_LVL_LO] = ~pin_i[n];
         raw_o[EV_BITS*n+EV_LVL_HI] = pin_i[n];
         raw_o[EV_BITS*n+EV_FALL]   = fall_q[n];
         raw_o[EV_BITS*n+EV_RISE]   = rise_q[n];
      end
   end

   assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_set.sv
`timescale 1ns/1ps
module gpio_irq_set import gpio_irq_pkg::*; #(
   parameter int                NUM_REGS   = 4,
   parameter int                IDX_W      = 2,
   parameter int                FLAT_W     = NUM_REGS * WORD_W,
   parameter logic [FLAT_W-1:0] VALID_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAT_W-1:0] raw_i,
   input  logic              en_we_i,
   input  logic              frc_we_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic [FLAT_W-1:0] en_o,
   output logic [FLAT_W-1:0] frc_o,
   output logic [FLAT_W-1:0] sts_o,
   output logic              irq_o
);
   logic [FLAT_W-1:0] en_q, frc_q;

   generate
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_q[r*WORD_W +: WORD_W]  <= '0;
               frc_q[r*WORD_W +: WORD_W] <= '0;
            end else if (idx_i == IDX_W'(r)) begin
               if (en_we_i)  en_q[r*WORD_W +: WORD_W]  <= wdata_i & VALID_MASK[r*WORD_W +: WORD_W];
               if (frc_we_i) frc_q[r*WORD_W +: WORD_W] <= wdata_i & VALID_MASK[r*WORD_W +: WORD_W];
            end
         end
      end
   endgenerate

   assign sts_o = (raw_i | frc_q) & en_q;
   assign irq_o = |sts_o;
   assign en_o  = en_q;
   assign frc_o = frc_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl import gpio_irq_pkg::*; #(
   parameter int  NUM_PINS    = 32,
   parameter int  SYNC_STAGES = 2,
   localparam int NUM_REGS    = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD,
   localparam int IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int ADDR_W      = REGION_W + IDX_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins_i,
   input  logic                bus_en_i,
   input  logic                bus_we_i,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic [WORD_W-1:0]   bus_wdata_i,
   output logic [WORD_W-1:0]   bus_rdata_o,
   output logic [NUM_SETS-1:0] irq_o
);
   localparam int                FLAT_W     = NUM_REGS * WORD_W;
   localparam int                EV_W       = NUM_PINS * EV_BITS;
   localparam logic [FLAT_W-1:0] VALID_MASK = FLAT_W'(low_mask(EV_W));

   generate
      if (NUM_PINS < 1 || NUM_PINS > 32) begin : g_bad_pins
         $error("gpio_irq_ctrl: NUM_PINS must be 1..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_irq_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [REGION_W-1:0] region;
   logic [IDX_W-1:0]    idx;
   logic                idx_ok, wr;

   assign region = bus_addr_i[ADDR_W-1:IDX_W];
   assign idx    = bus_addr_i[IDX_W-1:0];
   assign idx_ok = (int'(idx) < NUM_REGS);
   assign wr     = bus_en_i & bus_we_i & idx_ok;

   logic [NUM_PINS-1:0] pin_now, pin_prev;
   logic [FLAT_W-1:0]   clr_vec, raw_q;

   gpio_irq_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(pins_i), .sync_o(pin_now));

   generate
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_clr
         assign clr_vec[r*WORD_W +: WORD_W] =
            (wr && region == REGION_RAW && idx == IDX_W'(r)) ? bus_wdata_i : '0;
      end
   endgenerate

   gpio_irq_events #(.NUM_PINS(NUM_PINS), .FLAT_W(FLAT_W)) u_events (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_now), .clr_i(clr_vec),
      .raw_o(raw_q), .prev_o(pin_prev));

   logic [NUM_SETS-1:0][FLAT_W-1:0] en_all, frc_all, sts_all;

   generate
      for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
         gpio_irq_set #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .FLAT_W(FLAT_W),
                        .VALID_MASK(VALID_MASK)) u_set (
            .clk(clk), .rst_n(rst_n), .raw_i(raw_q),
            .en_we_i(wr && region == set_region(s, SEL_ENABLE)),
            .frc_we_i(wr && region == set_region(s, SEL_FORCE)),
            .idx_i(idx), .wdata_i(bus_wdata_i),
            .en_o(en_all[s]), .frc_o(frc_all[s]), .sts_o(sts_all[s]),
            .irq_o(irq_o[s]));
      end
   endgenerate

   always_comb begin
      bus_rdata_o = '0;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (bus_en_i && idx == IDX_W'(r)) begin
            if (region == REGION_RAW) bus_rdata_o = raw_q[r*WORD_W +: WORD_W];
            for (int s = 0; s < NUM_SETS; s++) begin
               if (region == set_region(s, SEL_ENABLE)) bus_rdata_o = en_all[s][r*WORD_W +: WORD_W];
               if (region == set_region(s, SEL_FORCE))  bus_rdata_o = frc_all[s][r*WORD_W +: WORD_W];
               if (region == set_region(s, SEL_STATUS)) bus_rdata_o = sts_all[s][r*WORD_W +: WORD_W];
            end
         end
      end
   end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_chk import gpio_irq_pkg::*; #(
   parameter int  NUM_PINS = 32,
   localparam int NUM_REGS = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD,
   localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int ADDR_W   = REGION_W + IDX_W,
   localparam int FLAT_W   = NUM_REGS * WORD_W
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [NUM_PINS-1:0]             pins_i,
   input logic                            bus_en_i,
   input logic                            bus_we_i,
   input logic [ADDR_W-1:0]               bus_addr_i,
   input logic [WORD_W-1:0]               bus_wdata_i,
   input logic [NUM_SETS-1:0]             irq_o,
   input logic [FLAT_W-1:0]               raw_q,
   input logic [NUM_PINS-1:0]             pin_now,
   input logic [NUM_PINS-1:0]             pin_prev,
   input logic [NUM_SETS-1:0][FLAT_W-1:0] en_all,
   input logic [NUM_SETS-1:0][FLAT_W-1:0] sts_all
);
   logic [1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             age_q <= '0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end

   // clear request seen from the bus pins
   logic [FLAT_W-1:0] bus_clr;
   always_comb begin
      bus_clr = '0;
      for (int r = 0; r < NUM_REGS; r++)
         if (bus_en_i && bus_we_i && bus_addr_i[ADDR_W-1:IDX_W] == '0 &&
             bus_addr_i[IDX_W-1:0] == IDX_W'(r))
            bus_clr[r*WORD_W +: WORD_W] = bus_wdata_i;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_IRQ_LOW: assert (irq_o == '0) else $error("irq during reset"); // R8
      end
   end

   generate
      for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
         AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[s] |-> (en_all[s] != '0)); // R7
         AST_STATUS_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_all[s] & ~en_all[s]) == '0); // R6
      end
      for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
         AST_RISE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (raw_q[4*n+EV_RISE] && !bus_clr[4*n+EV_RISE]) |=> raw_q[4*n+EV_RISE]); // R3
         AST_FALL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (raw_q[4*n+EV_FALL] && !bus_clr[4*n+EV_FALL]) |=> raw_q[4*n+EV_FALL]); // R3
         AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_now[n] && !pin_prev[n]) |=> raw_q[4*n+EV_RISE]); // R5
         AST_LEVEL_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q == 2'd3 && pins_i[n] == $past(pins_i[n]) && $past(pins_i[n]) == $past(pins_i[n], 2))
            |-> (raw_q[4*n+EV_LVL_HI] == pins_i[n] && raw_q[4*n+EV_LVL_LO] == !pins_i[n])); // R2
      end
   endgenerate
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .bus_en_i(bus_en_i),
   .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
   .irq_o(irq_o), .raw_q(raw_q), .pin_now(pin_now), .pin_prev(pin_prev),
   .en_all(en_all), .sts_all(sts_all));

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;
   localparam int NP     = 12;
   localparam int ADDR_W = 5;
   // regions
   localparam int RG_RAW = 0, RG_EN0 = 1, RG_STS0 = 3, RG_EN1 = 4, RG_FRC1 = 5,
                  RG_STS1 = 6, RG_EN2 = 7, RG_FRC2 = 8, RG_STS2 = 9, RG_NONE = 15;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NP-1:0]     pins = '0;
   logic              bus_en = 1'b0, bus_we = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [2:0]        irq;

   always #10 clk = ~clk;

   gpio_irq_ctrl #(.NUM_PINS(NP)) u_gpio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_en_i(bus_en), .bus_we_i(bus_we),
      .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq));

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   // monitor: compare mid-high phase after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            act = it.is_irq ? {29'b0, irq} : bus_rdata;
            compared++;
            if (act !== it.exp) begin
               mismatched++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic rd_chk(input int rg, input int idx, input logic [31:0] exp, input string tag);
      item_t it;
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0;
      bus_addr = ADDR_W'((rg << 1) | idx);
      it.is_irq = 1'b0; it.exp = exp; it.tag = tag;
      q.push_back(it);
      @(negedge clk);
      bus_en = 1'b0;
   endtask

   task automatic irq_chk(input logic [2:0] exp, input string tag);
      item_t it;
      @(negedge clk);
      it.is_irq = 1'b1; it.exp = {29'b0, exp}; it.tag = tag;
      q.push_back(it);
      @(negedge clk);
   endtask

   task automatic wr(input int rg, input int idx, input logic [31:0] data);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1;
      bus_addr = ADDR_W'((rg << 1) | idx);
      bus_wdata = data;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic set_pins(input logic [NP-1:0] v);
      @(negedge clk);
      pins = v;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R8 reset state, R2 levels with all pins low, R9 absent pins read zero
      irq_chk(3'b000, "R8 irq after reset");
      rd_chk(RG_EN0, 0, 32'h0, "R8 enable0 after reset");
      rd_chk(RG_RAW, 0, 32'h1111_1111, "R2 raw word0 all low");
      rd_chk(RG_RAW, 1, 32'h0000_1111, "R9 raw word1 absent pins zero");

      // R1 R2 R3 pin0 and pin9 rise
      set_pins(12'h201);
      rd_chk(RG_RAW, 0, 32'h1111_111A, "R1 R3 pin0 high+rise");
      rd_chk(RG_RAW, 1, 32'h0000_11A1, "R1 pin9 nibble in word1");

      // R2 level drops, R3 rise sticky, fall set
      set_pins(12'h200);
      rd_chk(RG_RAW, 0, 32'h1111_111D, "R2 R3 pin0 low, both edges held");

      // R4 clear fall only, level bit in write ignored; zero write no effect
      wr(RG_RAW, 0, 32'h0000_0005);
      rd_chk(RG_RAW, 0, 32'h1111_1119, "R4 fall cleared, level kept");
      wr(RG_RAW, 1, 32'h0000_0000);
      rd_chk(RG_RAW, 1, 32'h0000_11A1, "R4 zero write no effect");

      // R5 clear of rise coincides with a new rise
      @(negedge clk);
      pins = 12'h201;
      @(negedge clk);
      wr(RG_RAW, 0, 32'h0000_0008);
      repeat (3) @(negedge clk);
      rd_chk(RG_RAW, 0, 32'h1111_111A, "R5 new edge beats clear");

      // R6 R7 set0 enables pin0 rise
      wr(RG_EN0, 0, 32'h0000_0008);
      rd_chk(RG_STS0, 0, 32'h0000_0008, "R6 status0 masked raw");
      irq_chk(3'b001, "R7 only irq0 high");

      // R9 force/enable masking of absent pins in word1
      wr(RG_FRC1, 1, 32'hFFFF_FFFF);
      rd_chk(RG_FRC1, 1, 32'h0000_FFFF, "R9 force1 absent bits zero");
      wr(RG_EN1, 1, 32'h0001_0000);
      rd_chk(RG_EN1, 1, 32'h0000_0000, "R9 enable1 absent bit dropped");
      irq_chk(3'b001, "R7 irq1 stays low");
      wr(RG_EN1, 1, 32'h0000_0100);
      rd_chk(RG_STS1, 1, 32'h0000_0100, "R6 status1 from force");
      irq_chk(3'b011, "R7 irq1 from force");

      // R6 status ignores writes
      wr(RG_STS1, 1, 32'h0000_0000);
      rd_chk(RG_STS1, 1, 32'h0000_0100, "R6 status write ignored");

      // wake set on pin1 level low, then drop it
      wr(RG_EN2, 0, 32'h0000_0010);
      rd_chk(RG_STS2, 0, 32'h0000_0010, "R6 status2 pin1 low");
      irq_chk(3'b111, "R7 wake irq high");
      set_pins(12'h203);
      rd_chk(RG_STS2, 0, 32'h0000_0000, "R2 level event not held");
      irq_chk(3'b011, "R7 wake irq drops with level");
      rd_chk(RG_RAW, 0, 32'h1111_11AA, "R3 pin1 rise latched");

      // R4 R7 clearing pin0 rise drops irq0
      wr(RG_RAW, 0, 32'h0000_0008);
      rd_chk(RG_RAW, 0, 32'h1111_11A2, "R4 rise0 cleared");
      irq_chk(3'b010, "R7 irq0 low after clear");

      // R9 unused region and untouched force2
      rd_chk(RG_NONE, 0, 32'h0, "R9 unused region reads zero");
      rd_chk(RG_FRC2, 0, 32'h0, "R9 force2 untouched");

      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule